// File: doc/BRIEF.md
# Clock Source Supervisor

This block checks two fast clocks, one from a crystal and one from a PLL, against an internal RC reference that never stops. It also guards every change of the system clock. Each monitored clock is first divided by 2^DIV_STAGES (256 by default) in its own domain. The divided signal is brought into the reference domain through a two-flop synchroniser. Its rising edges are counted over a measurement window of fixed length. At the end of each window, the count is compared with a lower and an upper limit that software programs. There is one limit pair for each source and for each reference speed.

The system clock starts on the fast RC source. A request to move it to the crystal or the PLL is carried out only when that source currently holds its valid flag. A refused request sets a sticky flag. Once the system clock leaves the RC source, the reference runs in its slow mode. The supervisor then switches to the slow window length and the slow limit set, and it throws away any measurement that was in progress.

Repeated bad windows raise a fault. A fault drives a maskable interrupt, which the global enable does not gate. A fault, or a reset from an external watchdog, also sets a pin safe-state output at once, without waiting for a clock edge. That output is released only on a reference clock edge.

Top module: `cs_supervisor`

## Requirements
- R1: After reset, `sys_sel_o` is 0 (fast RC), `rc_slow_o` is 0, and `status_o`, `irq_o` and `pin_safe_o` are all 0.
- R2: In each window of WIN_FAST reference cycles, a running source reports in its count output the number of rising edges of its clock divided by 256, to within ±1.
- R3: Status bit layout: crystal bits 0 to 3 and PLL bits 4 to 7, each group in the order running, in-range, valid, fault; bit 8 is switch-rejected. A window with no divided edge clears running and gives a count of 0. A source is in range when its count is nonzero and lies between min and max, both limits included.
- R4: The valid flag is set by a single in-range window and cleared by any window that is not in range.
- R5: The fault flag is set on the second of two consecutive windows that are not in range. A stopped source counts as not in range. A single bad window never sets it.
- R6: A write of value v to SEL (address 1, bits 1:0; 0 = RC, 1 = crystal, 2 = PLL) changes `sys_sel_o` only when v is 0 or the named source is valid. In every other case, including v = 3, `sys_sel_o` stays unchanged and the sticky switch-rejected bit is set.
- R7: While `sys_sel_o` is not 0, `rc_slow_o` is 1 and windows are WIN_SLOW cycles long. Limits live at address 8 + 4·source + 2·slow + is_max. A change of mode discards the partial window, so the first result after the change is a full window counted at the new length.
- R8: A write to STATUS (address 2) clears each valid, fault or switch-rejected bit whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R9: CTRL (address 0) holds bit 0 crystal monitor enable, bit 1 PLL monitor enable, bit 2 fault interrupt enable and bit 3 global enable. `irq_o` is registered and equals (bit 2 AND any fault) OR (bit 3 AND switch-rejected). The global enable never masks the fault term.
- R10: `pin_safe_o` goes to 1 without waiting for a clock edge when `ext_wdog_i` is high or any fault flag is set. It returns to 0 on a clock edge only when there is neither watchdog nor fault, and the selected source is RC or valid.
- R11: When a source's monitor enable is 0, its four status bits and its count are held at 0, and it never raises a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RC reference clock |
| rst | input | 1 | Synchronous active-high reset |
| xtal_clk_i | input | 1 | Crystal oscillator clock under supervision |
| pll_clk_i | input | 1 | PLL clock under supervision |
| ext_wdog_i | input | 1 | External watchdog reset request, acts without a clock |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | CNT_W | Register write data |
| sys_sel_o | output | 2 | Active system clock source (0 RC, 1 crystal, 2 PLL) |
| rc_slow_o | output | 1 | Reference is in its slow mode |
| status_o | output | 9 | Per-source status and switch-rejected flag |
| xtal_count_o | output | CNT_W | Crystal count from the last completed window |
| pll_count_o | output | CNT_W | PLL count from the last completed window |
| irq_o | output | 1 | Oscillator fault / switch-rejected interrupt |
| pin_safe_o | output | 1 | Drive port pins to their safe levels |

## Verification
Register writes take effect at the clock edge that samples them. Selection and the clearable flags can therefore be read at the following falling edge, and `irq_o` one cycle after that. Any window result appears only after a full window, plus three cycles through the synchroniser and edge detector. For that reason the bench waits at least one full window plus a 20-cycle margin before it reads a count or a flag. Where it must show that a single bad window is harmless, it polls for the in-range bit to drop and samples the fault bit in that same cycle. The asynchronous watchdog path is sampled half a nanosecond after the input rises, well before the next rising edge.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef enum logic [1:0] {
    SRC_RC   = 2'd0,
    SRC_XTAL = 2'd1,
    SRC_PLL  = 2'd2
  } src_e;

  localparam int NSRC   = 2;
  localparam int ADDR_W = 4;
  localparam int STAT_W = 9;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_SEL  = 4'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd2;

  // per-source status group, packed so that running is the lowest bit
  typedef struct packed {
    logic fault;
    logic valid;
    logic in_range;
    logic running;
  } src_stat_t;
endpackage

// File: rtl/cs_prescaler.sv
// Cascaded binary divider running in the monitored clock's own domain.
module cs_prescaler #(
  parameter int STAGES = 8
) (
  input  logic src_clk,
  input  logic rst,
  output logic div_o
);
  logic [STAGES-1:0] stage_q;

  always_ff @(posedge src_clk) begin
    if (rst) stage_q <= '0;
    else     stage_q <= stage_q + 1'b1;
  end

  assign div_o = stage_q[STAGES-1];
endmodule

// File: rtl/cs_edge_sync.sv
// Two-flop synchroniser into the reference domain plus rising-edge detect.
module cs_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= async_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;
endmodule

// File: rtl/cs_window_timer.sv
// Shared measurement window; length follows the reference mode, flush restarts it.
module cs_window_timer #(
  parameter int WIN_FAST = 4096,
  parameter int WIN_SLOW = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic slow_i,
  input  logic flush_i,
  output logic tick_o
);
  localparam int WMAX = (WIN_FAST > WIN_SLOW) ? WIN_FAST : WIN_SLOW;
  localparam int TW   = $clog2(WMAX) + 1;
  localparam logic [TW-1:0] LAST_FAST = TW'(WIN_FAST - 1);
  localparam logic [TW-1:0] LAST_SLOW = TW'(WIN_SLOW - 1);

  logic [TW-1:0] tmr_q;
  logic [TW-1:0] last;

  assign last   = slow_i ? LAST_SLOW : LAST_FAST;
  assign tick_o = !flush_i && (tmr_q == last);

  always_ff @(posedge clk) begin
    if (rst || flush_i) tmr_q <= '0;
    else if (tick_o)    tmr_q <= '0;
    else                tmr_q <= tmr_q + 1'b1;
  end
endmodule

// File: rtl/cs_source_eval.sv
// Edge counter and window evaluation for one monitored source.
module cs_source_eval
  import cs_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             edge_i,
  input  logic             tick_i,
  input  logic             flush_i,
  input  logic [CNT_W-1:0] lim_min_i,
  input  logic [CNT_W-1:0] lim_max_i,
  input  logic             clr_valid_i,
  input  logic             clr_fault_i,
  output src_stat_t        stat_o,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] sample;
  logic             bump;
  logic             eval;
  logic             good;
  logic             prev_bad_q;

  assign bump   = edge_i && (cnt_q != CNT_MAX);
  assign sample = bump ? cnt_q + 1'b1 : cnt_q;
  assign eval   = en_i && tick_i && !flush_i;
  assign good   = (sample != '0) && (sample >= lim_min_i) && (sample <= lim_max_i);

  always_ff @(posedge clk) begin
    if (rst || !en_i || flush_i || tick_i) cnt_q <= '0;
    else if (bump)                          cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      stat_o     <= '0;
      count_o    <= '0;
      prev_bad_q <= 1'b0;
    end else begin
      if (flush_i) prev_bad_q <= 1'b0;
      if (eval) begin
        count_o         <= sample;
        stat_o.running  <= (sample != '0);
        stat_o.in_range <= good;
        stat_o.valid    <= good;
        prev_bad_q      <= !good;
        stat_o.fault    <= (stat_o.fault && !clr_fault_i) || (!good && prev_bad_q);
      end else begin
        if (clr_valid_i) stat_o.valid <= 1'b0;
        if (clr_fault_i) stat_o.fault <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cs_supervisor.sv
// Clock source supervisor top: register file, select guard, safe-state latch.
module cs_supervisor
  import cs_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int DIV_STAGES = 8,
  parameter int WIN_FAST   = 4096,
  parameter int WIN_SLOW   = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xtal_clk_i,
  input  logic              pll_clk_i,
  input  logic              ext_wdog_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [1:0]        sys_sel_o,
  output logic              rc_slow_o,
  output logic [STAT_W-1:0] status_o,
  output logic [CNT_W-1:0]  xtal_count_o,
  output logic [CNT_W-1:0]  pll_count_o,
  output logic              irq_o,
  output logic              pin_safe_o
);
  localparam int NLIM = 2 * NSRC * 2;

  // ---------------- register file ----------------
  logic [NSRC-1:0]  mon_en_q;
  logic             osc_irq_en_q;
  logic             irq_glb_en_q;
  logic             sw_rej_q;
  logic [CNT_W-1:0] lim_q [NLIM];
  src_e             sel_q;

  logic wr_ctrl, wr_sel, wr_stat, wr_lim;
  assign wr_ctrl = wr_en_i && (wr_addr_i == A_CTRL);
  assign wr_sel  = wr_en_i && (wr_addr_i == A_SEL);
  assign wr_stat = wr_en_i && (wr_addr_i == A_STAT);
  assign wr_lim  = wr_en_i && wr_addr_i[ADDR_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      mon_en_q     <= '0;
      osc_irq_en_q <= 1'b0;
      irq_glb_en_q <= 1'b0;
    end else if (wr_ctrl) begin
      mon_en_q     <= wr_data_i[NSRC-1:0];
      osc_irq_en_q <= wr_data_i[2];
      irq_glb_en_q <= wr_data_i[3];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NLIM; i++) lim_q[i] <= '0;
    end else if (wr_lim) begin
      lim_q[wr_addr_i[2:0]] <= wr_data_i;
    end
  end

  // ---------------- per-source monitoring ----------------
  logic [NSRC-1:0] src_clk;
  logic            slow;
  logic            mode_q;
  logic            flush;
  logic            tick;
  src_stat_t       stat   [NSRC];
  logic [CNT_W-1:0] count [NSRC];

  assign src_clk = {pll_clk_i, xtal_clk_i};
  assign slow    = (sel_q != SRC_RC);
  assign flush   = (slow != mode_q);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 1'b0;
    else     mode_q <= slow;
  end

  cs_window_timer #(
    .WIN_FAST (WIN_FAST),
    .WIN_SLOW (WIN_SLOW)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .slow_i  (slow),
    .flush_i (flush),
    .tick_o  (tick)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    localparam logic SB = 1'(s);
    logic div_sig;
    logic rise;

    cs_prescaler #(
      .STAGES (DIV_STAGES)
    ) u_div (
      .src_clk (src_clk[s]),
      .rst     (rst),
      .div_o   (div_sig)
    );

    cs_edge_sync u_sync (
      .clk     (clk),
      .rst     (rst),
      .async_i (div_sig),
      .rise_o  (rise)
    );

    cs_source_eval #(
      .CNT_W (CNT_W)
    ) u_eval (
      .clk         (clk),
      .rst         (rst),
      .en_i        (mon_en_q[s]),
      .edge_i      (rise),
      .tick_i      (tick),
      .flush_i     (flush),
      .lim_min_i   (lim_q[{SB, slow, 1'b0}]),
      .lim_max_i   (lim_q[{SB, slow, 1'b1}]),
      .clr_valid_i (wr_stat && wr_data_i[4*s+2]),
      .clr_fault_i (wr_stat && wr_data_i[4*s+3]),
      .stat_o      (stat[s]),
      .count_o     (count[s])
    );
  end

  assign xtal_count_o = count[0];
  assign pll_count_o  = count[1];
  assign status_o     = {sw_rej_q, stat[1], stat[0]};

  // ---------------- guarded clock selection ----------------
  logic [1:0] req;
  logic       req_ok;
  assign req = wr_data_i[1:0];

  always_comb begin
    case (req)
      SRC_RC:   req_ok = 1'b1;
      SRC_XTAL: req_ok = stat[0].valid;
      SRC_PLL:  req_ok = stat[1].valid;
      default:  req_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= SRC_RC;
      sw_rej_q <= 1'b0;
    end else begin
      if (wr_sel && req_ok) sel_q <= src_e'(req);
      if (wr_sel && !req_ok)                  sw_rej_q <= 1'b1;
      else if (wr_stat && wr_data_i[STAT_W-1]) sw_rej_q <= 1'b0;
    end
  end

  assign sys_sel_o = sel_q;
  assign rc_slow_o = slow;

  // ---------------- interrupt ----------------
  logic fault_any;
  assign fault_any = stat[0].fault | stat[1].fault;

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= (osc_irq_en_q & fault_any) | (irq_glb_en_q & sw_rej_q);
  end

  // ---------------- safe-state latch ----------------
  logic safe_set;
  logic sel_ok;
  logic safe_q;

  assign safe_set = ext_wdog_i | fault_any;
  assign sel_ok   = (sel_q == SRC_RC) ||
                    ((sel_q == SRC_XTAL) && stat[0].valid) ||
                    ((sel_q == SRC_PLL)  && stat[1].valid);

  always_ff @(posedge clk or posedge safe_set) begin
    if (safe_set)    safe_q <= 1'b1;
    else if (rst)    safe_q <= 1'b0;
    else if (sel_ok) safe_q <= 1'b0;
  end

  assign pin_safe_o = safe_q;
endmodule

// File: rtl/cs_supervisor_chk.sv
module cs_supervisor_chk (
  input logic       clk,
  input logic       rst,
  input logic       ext_wdog_i,
  input logic       wr_en_i,
  input logic [3:0] wr_addr_i,
  input logic [1:0] wr_req,
  input logic [1:0] sys_sel_o,
  input logic [8:0] status_o,
  input logic       irq_o,
  input logic       pin_safe_o,
  input logic       osc_irq_en_q
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (sys_sel_o == 2'd0) && (status_o == '0));

  // R6
  switch_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sys_sel_o) && sys_sel_o == 2'd1) |-> $past(status_o[2]));

  // R6
  switch_guard_pll_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sys_sel_o) && sys_sel_o == 2'd2) |-> $past(status_o[6]));

  // R6
  reject_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_addr_i == 4'd1 && wr_req == 2'd2 && !status_o[6]) |=> status_o[8]);

  // R9
  fault_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (osc_irq_en_q && (status_o[3] || status_o[7])) |=> irq_o);

  // R10
  safe_set_chk: assert property (@(posedge clk) disable iff (rst)
    (ext_wdog_i || status_o[3] || status_o[7]) |-> pin_safe_o);

  // R10
  safe_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pin_safe_o) |-> !ext_wdog_i && !status_o[3] && !status_o[7]);
endmodule

bind cs_supervisor cs_supervisor_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .ext_wdog_i   (ext_wdog_i),
  .wr_en_i      (wr_en_i),
  .wr_addr_i    (wr_addr_i),
  .wr_req       (wr_data_i[1:0]),
  .sys_sel_o    (sys_sel_o),
  .status_o     (status_o),
  .irq_o        (irq_o),
  .pin_safe_o   (pin_safe_o),
  .osc_irq_en_q (osc_irq_en_q)
);

// File: tb/cs_supervisor_tb.sv
`timescale 1ns/1ps
module cs_supervisor_tb;
  localparam int    WF = 1024;
  localparam int    WS = 256;
  localparam real   TCLK = 5.0;
  localparam real   TX = 2.0;
  localparam real   TP = 1.0;
  localparam int    XR = 0, XI = 1, XV = 2, XF = 3;
  localparam int    PR = 4, PV = 6, PF = 7, SR = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic xtal_clk = 1'b0, pll_clk = 1'b0;
  logic xtal_run = 1'b1, pll_run = 1'b1;
  logic ext_wdog = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0] sys_sel;
  logic rc_slow, irq, pin_safe;
  logic [8:0] status;
  logic [15:0] xcnt, pcnt;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always begin #(TX/2); if (xtal_run) xtal_clk = ~xtal_clk; end
  always begin #(TP/2); if (pll_run) pll_clk = ~pll_clk; end

  cs_supervisor #(.CNT_W(16), .DIV_STAGES(8), .WIN_FAST(WF), .WIN_SLOW(WS)) u_dut (
    .clk(clk), .rst(rst), .xtal_clk_i(xtal_clk), .pll_clk_i(pll_clk),
    .ext_wdog_i(ext_wdog), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .sys_sel_o(sys_sel), .rc_slow_o(rc_slow), .status_o(status),
    .xtal_count_o(xcnt), .pll_count_o(pcnt), .irq_o(irq), .pin_safe_o(pin_safe));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  // expected count window: exact edges per window +-1, integers only
  function automatic int exp_lo(input int win, input real tsrc);
    real e = win * TCLK / (256.0 * tsrc);
    return int'($ceil(e - 1.0));
  endfunction
  function automatic int exp_hi(input int win, input real tsrc);
    real e = win * TCLK / (256.0 * tsrc);
    return int'($floor(e + 1.0));
  endfunction

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(190000 * TCLK);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int xlo, xhi, plo, phi;
    xlo = exp_lo(WF, TX); xhi = exp_hi(WF, TX);
    plo = exp_lo(WF, TP); phi = exp_hi(WF, TP);

    cyc(20);
    chk("R1 sys_sel", sys_sel, 0);
    chk("R1 rc_slow", rc_slow, 0);
    chk("R1 status", status, 0);
    chk("R1 irq", irq, 0);
    chk("R1 pin_safe", pin_safe, 0);
    rst = 1'b0;

    // limits: addr 8 + 4*src + 2*slow + is_max
    wr(4'd8, 16'(xlo - 1));  wr(4'd9, 16'(xhi + 1));
    wr(4'd10, 16'd1);        wr(4'd11, 16'd4);
    wr(4'd12, 16'(plo - 2)); wr(4'd13, 16'(phi + 2));
    wr(4'd14, 16'd3);        wr(4'd15, 16'd7);
    wr(4'd0, 16'b0111);
    cyc(3 * WF + 20);
    chk_rng("R2 xtal count", xcnt, xlo, xhi);
    chk_rng("R2 pll count", pcnt, plo, phi);
    chk("R3 xtal running", status[XR], 1);
    chk("R3 pll running", status[PR], 1);
    chk("R4 xtal valid", status[XV], 1);
    chk("R4 pll valid", status[PV], 1);
    chk("R5 no fault", status[XF] | status[PF], 0);
    chk("R10 pins free", pin_safe, 0);

    // R3 limit sweep on the crystal source
    for (int lo = xlo - 4; lo <= xhi + 4; lo += 2) begin
      for (int hi = lo; hi <= lo + 6; hi += 3) begin
        wr(4'd8, 16'(lo)); wr(4'd9, 16'(hi));
        cyc(WF + 20);
        if (lo <= xlo && hi >= xhi)      chk("R3 sweep inside", status[XI], 1);
        else if (hi < xlo || lo > xhi)   chk("R3 sweep outside", status[XI], 0);
      end
    end
    wr(4'd8, 16'(xlo - 1)); wr(4'd9, 16'(xhi + 1));
    cyc(2 * WF + 20);
    wr(4'd2, 16'h0088);
    cyc(3);
    chk("R8 fault cleared", status[XF], 0);
    chk("R8 valid kept", status[XV], 1);
    chk("R10 release", pin_safe, 0);

    // R4/R5: one bad window does not fault, the second does
    wr(4'd9, 16'(xlo - 3));
    for (int i = 0; i < 2 * WF && status[XI]; i++) @(negedge clk);
    chk("R5 single bad window", status[XF], 0);
    chk("R4 valid dropped", status[XV], 0);
    cyc(WF + 20);
    chk("R5 second bad window", status[XF], 1);
    chk("R10 safe on fault", pin_safe, 1);
    chk("R9 fault irq", irq, 1);

    // R8: writing zero has no effect, writing one clears
    wr(4'd2, 16'h0000);
    cyc(2);
    chk("R8 zero write", status[XF], 1);
    wr(4'd9, 16'(xhi + 1));
    cyc(WF + 20);
    chk("R4 valid after one window", status[XV], 1);
    wr(4'd2, 16'h0008);
    cyc(3);
    chk("R8 one write", status[XF], 0);
    chk("R8 valid untouched", status[XV], 1);
    chk("R10 release after clear", pin_safe, 0);
    chk("R9 irq gone", irq, 0);

    // stopped PLL, guard and interrupt gating
    pll_run = 1'b0;
    wr(4'd0, 16'b0011);
    cyc(3 * WF + 20);
    chk("R3 pll stopped", status[PR], 0);
    chk("R3 pll count zero", pcnt, 0);
    chk("R5 stopped faults", status[PF], 1);
    chk("R9 fault irq masked", irq, 0);
    wr(4'd1, 16'd2);
    chk("R6 pll refused", sys_sel, 0);
    chk("R6 reject flag", status[SR], 1);
    cyc(2);
    chk("R9 gie off", irq, 0);
    wr(4'd0, 16'b1011);
    cyc(2);
    chk("R9 gie on", irq, 1);
    wr(4'd0, 16'b0111);
    wr(4'd2, 16'h0100);
    cyc(2);
    chk("R8 reject cleared", status[SR], 0);
    chk("R9 fault irq ignores gie", irq, 1);
    wr(4'd1, 16'd3);
    chk("R6 code 3 refused", sys_sel, 0);
    chk("R6 code 3 flag", status[SR], 1);

    // R11: disabled monitor
    wr(4'd0, 16'b0101);
    cyc(3 * WF + 20);
    chk("R11 pll bits", status[7:4], 0);
    chk("R11 pll count", pcnt, 0);
    chk("R11 pins free", pin_safe, 0);
    wr(4'd2, 16'h0100);
    pll_run = 1'b1;
    wr(4'd0, 16'b0111);
    cyc(2 * WF + 20);
    chk("R4 pll valid again", status[PV], 1);
    chk("R5 pll no fault", status[PF], 0);

    // R10: asynchronous watchdog path
    @(negedge clk); #1.0 ext_wdog = 1'b1;
    #0.5 chk("R10 async set", pin_safe, 1);
    cyc(3);
    chk("R10 held", pin_safe, 1);
    ext_wdog = 1'b0;
    cyc(3);
    chk("R10 sync release", pin_safe, 0);

    // R7: slow mode, flush and slow limits
    wr(4'd1, 16'd1);
    chk("R6 xtal accepted", sys_sel, 1);
    chk("R7 slow", rc_slow, 1);
    cyc(WS + 20);
    chk_rng("R7 xtal slow count", xcnt, exp_lo(WS, TX), exp_hi(WS, TX));
    chk_rng("R7 pll slow count", pcnt, exp_lo(WS, TP), exp_hi(WS, TP));
    cyc(3 * WS);
    chk("R7 no fault slow", status[XF] | status[PF], 0);
    chk("R7 xtal valid slow", status[XV], 1);
    wr(4'd1, 16'd2);
    chk("R6 pll accepted", sys_sel, 2);
    chk("R7 still slow", rc_slow, 1);
    wr(4'd1, 16'd0);
    chk("R7 fast again", rc_slow, 0);
    cyc(WF + 20);
    chk_rng("R7 fast count", xcnt, xlo, xhi);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule